// File: doc/BRIEF.md
# Bicolor Status LED Encoder

This block turns a set of supply condition flags into drive levels for a front-panel lamp with a green die and a yellow die. A fixed priority picks one display mode from the flags. Each mode is one of three styles: steady, slow blink or fast blink. With the default parameter and a 100 MHz clock, the slow blink runs at 1 Hz and the fast blink at 2 Hz. Every blink has a 50% duty cycle.

A prescaler makes a tick every `HALF_FAST_CYC` clocks. A two-bit phase counter advances on each tick. The fast blink follows phase bit 0 and the slow blink follows phase bit 1. When the selected mode changes, the prescaler and the phase restart, so every new pattern begins with its lit half. The block also drives an alert line that is high whenever steady yellow is shown.

The flags are sampled on every clock. The chosen mode is registered, so the lamp follows the flags one clock later.

Top module: `status_led_enc`

## Requirements
- R1: With `crit` high, the lamp is steady yellow, whatever the other flags are.
- R2: With `lost_in_partner` high and `crit` low, the lamp is steady yellow.
- R3: With `fw_upd` high and `crit` and `lost_in_partner` low, green blinks fast: lit for `HALF_FAST_CYC` clocks, then dark for `HALF_FAST_CYC` clocks. Yellow stays dark.
- R4: With `warn` high and the three flags above low, yellow blinks slow: lit for 2·`HALF_FAST_CYC` clocks, then dark for 2·`HALF_FAST_CYC` clocks. Green stays dark.
- R5: With `main_ok` high and every flag above low, the lamp is steady green.
- R6: With `stby_only` and `in_pwr` both high and every flag above low, green blinks slow with the timing of R4. `stby_only` without `in_pwr` has no effect and the lamp stays dark.
- R7: With no condition of R1 to R6 present, and during reset, both colours and `alert` are low.
- R8: `alert` is high exactly when the displayed mode is steady yellow (R1 or R2), and low in every other mode.
- R9: A change of displayed mode restarts the blink at the start of its lit half. A flag change that leaves the displayed mode unchanged does not disturb the blink phase.
- R10: `led_green` and `led_yellow` are never high in the same cycle.
- R11: The outputs reflect the flags that were sampled at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_pwr | input | 1 | Local input power present |
| stby_only | input | 1 | Only standby is up, or the unit is in hot standby |
| main_ok | input | 1 | Main output on and in regulation |
| warn | input | 1 | A warning is active and the unit keeps running |
| crit | input | 1 | A critical event has shut the unit down |
| fw_upd | input | 1 | Firmware update in progress |
| lost_in_partner | input | 1 | Local input lost while a parallel unit still has power |
| led_green | output | 1 | Green die drive |
| led_yellow | output | 1 | Yellow die drive |
| alert | output | 1 | Alert, high while steady yellow is displayed |

## Verification
A change of mode can land on the same clock as a prescaler wrap. In that cycle the restart (R9) has to win over the phase advance. A second sweep changes the flags every five clocks with a three-clock prescaler, so the changes fall on every prescaler position, including the wrap. A model of the requirements expects phase zero after each change. The alert and the colour switch also change together on each change into or out of steady yellow. Each cycle is judged on `alert`, both colours and their exclusion at the same sample.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

    typedef enum logic [2:0] {
        DISP_DARK     = 3'd0,
        DISP_G_STEADY = 3'd1,
        DISP_G_SLOW   = 3'd2,
        DISP_G_FAST   = 3'd3,
        DISP_Y_STEADY = 3'd4,
        DISP_Y_SLOW   = 3'd5
    } disp_e;

    typedef struct packed {
        logic crit;
        logic partner;
        logic fw;
        logic warn;
        logic main_ok;
        logic stby;
        logic in_pwr;
    } flags_t;

    typedef struct packed {
        logic green;
        logic yellow;
        logic alert;
    } lamp_t;

    // Fixed priority: shutdown, partner-held, update, warning, main, standby.
    function automatic disp_e pick_disp(input flags_t f);
        if (f.crit)                 return DISP_Y_STEADY;
        else if (f.partner)         return DISP_Y_STEADY;
        else if (f.fw)              return DISP_G_FAST;
        else if (f.warn)            return DISP_Y_SLOW;
        else if (f.main_ok)         return DISP_G_STEADY;
        else if (f.stby && f.in_pwr) return DISP_G_SLOW;
        else                        return DISP_DARK;
    endfunction

endpackage

// File: rtl/led_prio_sel.sv
module led_prio_sel
    import led_enc_pkg::*;
(
    input  flags_t flags,
    output disp_e  disp
);

    always_comb begin
        disp = pick_disp(flags);
    end

endmodule

// File: rtl/led_phase_gen.sv
module led_phase_gen #(
    parameter int HALF_FAST_CYC = 25_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    output logic [1:0] phase
);

    localparam int PW = $clog2(HALF_FAST_CYC + 1);
    localparam logic [PW-1:0] PRE_LAST = PW'(HALF_FAST_CYC - 1);

    logic [PW-1:0] pre_q;
    logic [1:0]    ph_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            pre_q <= '0;
            ph_q  <= '0;
        end else if (pre_q == PRE_LAST) begin
            pre_q <= '0;
            ph_q  <= ph_q + 2'd1;
        end else begin
            pre_q <= pre_q + PW'(1);
        end
    end

    assign phase = ph_q;

endmodule

// File: rtl/led_color_map.sv
module led_color_map
    import led_enc_pkg::*;
(
    input  disp_e      disp,
    input  logic [1:0] phase,
    output lamp_t      lamp
);

    always_comb begin
        lamp = '0;
        unique case (disp)
            DISP_G_STEADY: lamp.green  = 1'b1;
            DISP_G_SLOW:   lamp.green  = ~phase[1];
            DISP_G_FAST:   lamp.green  = ~phase[0];
            DISP_Y_STEADY: begin
                lamp.yellow = 1'b1;
                lamp.alert  = 1'b1;
            end
            DISP_Y_SLOW:   lamp.yellow = ~phase[1];
            default:       lamp = '0;
        endcase
    end

endmodule

// File: rtl/status_led_enc.sv
module status_led_enc
    import led_enc_pkg::*;
#(
    parameter int HALF_FAST_CYC = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic in_pwr,
    input  logic stby_only,
    input  logic main_ok,
    input  logic warn,
    input  logic crit,
    input  logic fw_upd,
    input  logic lost_in_partner,
    output logic led_green,
    output logic led_yellow,
    output logic alert
);

    flags_t     flags;
    disp_e      disp_d;
    disp_e      disp_q;
    logic       restart;
    logic [1:0] phase;
    lamp_t      lamp;

    always_comb begin
        flags         = '0;
        flags.crit    = crit;
        flags.partner = lost_in_partner;
        flags.fw      = fw_upd;
        flags.warn    = warn;
        flags.main_ok = main_ok;
        flags.stby    = stby_only;
        flags.in_pwr  = in_pwr;
    end

    led_prio_sel u_sel (
        .flags (flags),
        .disp  (disp_d)
    );

    assign restart = (disp_d != disp_q);

    always_ff @(posedge clk) begin
        if (rst) disp_q <= DISP_DARK;
        else     disp_q <= disp_d;
    end

    led_phase_gen #(
        .HALF_FAST_CYC (HALF_FAST_CYC)
    ) u_phase (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .phase   (phase)
    );

    led_color_map u_map (
        .disp  (disp_q),
        .phase (phase),
        .lamp  (lamp)
    );

    assign led_green  = lamp.green;
    assign led_yellow = lamp.yellow;
    assign alert      = lamp.alert;

endmodule

// File: rtl/led_enc_chk.sv
module led_enc_chk (
    input logic clk,
    input logic rst,
    input logic in_pwr,
    input logic stby_only,
    input logic main_ok,
    input logic warn,
    input logic crit,
    input logic fw_upd,
    input logic lost_in_partner,
    input logic led_green,
    input logic led_yellow,
    input logic alert
);

    AST_COLORS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(led_green && led_yellow)); // R10

    AST_ALERT_IS_YELLOW: assert property (@(posedge clk) disable iff (rst)
        alert |-> (led_yellow && !led_green)); // R8

    AST_CRIT_ALERT: assert property (@(posedge clk) disable iff (rst)
        crit |=> (alert && led_yellow)); // R1

    AST_PARTNER_ALERT: assert property (@(posedge clk) disable iff (rst)
        (lost_in_partner && !crit) |=> (alert && led_yellow)); // R2

    AST_NO_ALERT_ELSE: assert property (@(posedge clk) disable iff (rst)
        (!crit && !lost_in_partner) |=> !alert); // R8

    AST_MAIN_GREEN: assert property (@(posedge clk) disable iff (rst)
        (main_ok && !crit && !lost_in_partner && !fw_upd && !warn)
        |=> (led_green && !led_yellow)); // R5

    AST_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
        (!crit && !lost_in_partner && !fw_upd && !warn && !main_ok
         && !(stby_only && in_pwr))
        |=> (!led_green && !led_yellow && !alert)); // R7

endmodule

bind status_led_enc led_enc_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .in_pwr          (in_pwr),
    .stby_only       (stby_only),
    .main_ok         (main_ok),
    .warn            (warn),
    .crit            (crit),
    .fw_upd          (fw_upd),
    .lost_in_partner (lost_in_partner),
    .led_green       (led_green),
    .led_yellow      (led_yellow),
    .alert           (alert)
);

// File: tb/status_led_enc_test.sv
module status_led_enc_test;

    localparam int H = 3;
    localparam int P = 4 * H;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_pwr = 0, stby_only = 0, main_ok = 0, warn = 0;
    logic crit = 0, fw_upd = 0, lost_in_partner = 0;
    logic led_green, led_yellow, alert;

    int nchk  = 0;
    int nfail = 0;
    int m_mode = 0;   // 0 dark,1 g steady,2 g slow,3 g fast,4 y steady,5 y slow
    int m_j    = 0;
    logic [6:0] cur = '0;

    always #5 clk = ~clk;

    status_led_enc #(.HALF_FAST_CYC(H)) uut (
        .clk(clk), .rst(rst), .in_pwr(in_pwr), .stby_only(stby_only),
        .main_ok(main_ok), .warn(warn), .crit(crit), .fw_upd(fw_upd),
        .lost_in_partner(lost_in_partner),
        .led_green(led_green), .led_yellow(led_yellow), .alert(alert)
    );

    // bit 6 crit, 5 partner, 4 fw, 3 warn, 2 main, 1 stby, 0 in_pwr
    function automatic int exp_mode(input logic [6:0] v);
        if (v[6])              return 4;
        else if (v[5])         return 4;
        else if (v[4])         return 3;
        else if (v[3])         return 5;
        else if (v[2])         return 1;
        else if (v[1] && v[0]) return 2;
        else                   return 0;
    endfunction

    function automatic string req_of(input int md, input logic [6:0] v);
        case (md)
            1: return "R5";
            2: return "R6";
            3: return "R3";
            4: return v[6] ? "R1" : "R2";
            5: return "R4";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %b expected %b (flags %b, t=%0t)", req, what, act, exp, cur, $time);
        end
    endtask

    task automatic drive(input logic [6:0] v);
        cur = v;
        crit = v[6]; lost_in_partner = v[5]; fw_upd = v[4]; warn = v[3];
        main_ok = v[2]; stby_only = v[1]; in_pwr = v[0];
    endtask

    task automatic cycle();
        int nm;
        logic eg, ey;
        int ph;
        @(posedge clk);
        if (rst) begin
            m_mode = 0; m_j = 0;
        end else begin
            nm = exp_mode(cur);
            if (nm != m_mode) begin m_mode = nm; m_j = 0; end
            else m_j = (m_j + 1) % P;
        end
        @(negedge clk);
        ph = m_j / H;
        eg = (m_mode == 1) || (m_mode == 2 && ph < 2) || (m_mode == 3 && (ph % 2) == 0);
        ey = (m_mode == 4) || (m_mode == 5 && ph < 2);
        chk(req_of(m_mode, cur), led_green, eg, "green");
        chk(req_of(m_mode, cur), led_yellow, ey, "yellow");
        chk("R8", alert, (m_mode == 4), "alert");
        chk("R10", led_green & led_yellow, 1'b0, "both colours");
    endtask

    initial begin
        #(200000 * 10);
        nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        drive(7'h7f);
        repeat (3) cycle();                 // R7 reset state dark despite flags
        @(negedge clk);
        drive('0);
        rst = 1'b0;
        cycle();

        // R11: main_ok shows green one clock after it is sampled
        @(negedge clk);
        drive(7'b0000100);
        @(posedge clk);
        #1;
        chk("R11", led_green, 1'b1, "green after one edge");
        m_mode = 1; m_j = 0;
        @(negedge clk);
        drive('0);
        cycle();

        // R9: flag change without a mode change keeps the phase
        drive(7'b0001000);
        repeat (2 * H + 1) cycle();        // now in dark half of slow yellow
        drive(7'b0001100);                 // main_ok too, warn still wins
        cycle();
        chk("R9", led_yellow, 1'b0, "no restart on same mode");
        drive(7'b0010000);                 // mode change: fast green restarts lit
        cycle();
        chk("R9", led_green, 1'b1, "restart lit after change");

        // Exhaustive sweep, two full slow periods per combination
        for (int i = 0; i < 128; i++) begin
            drive(7'(i));
            repeat (2 * P) cycle();
        end

        // Scrambled sweep with changes every 5 clocks (all prescaler positions)
        for (int i = 0; i < 256; i++) begin
            drive(7'((i * 37 + 11) % 128));
            repeat (5) cycle();
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule